// File: doc/BRIEF.md
# Serial Port Register and Interrupt File

This block is the software-visible front of a simple byte-wide serial port. It sits on an APB slave port and decodes a 4 KB address window. The window holds a data register, a state register, a control register, an interrupt-status register, a baud-divisor register and twelve read-only identification words. The bit timing, the shift registers and the pins live in separate transmit and receive datapaths. This block trades strobes and flags with them. It hands a byte to the transmitter with a one-cycle load pulse. It takes a completion pulse back, and it captures bytes that the receiver presents with a valid pulse.

Each of the two directions has a full flag, which acts as a one-entry buffer, and an overrun flag. The transmit and receive interrupt bits are latched events that software clears by writing one to them. The two overrun interrupt bits are not latched. Each is the live AND of an overrun flag and its enable. Clearing either overrun interrupt bit clears the overrun flag under it. Five interrupt lines leave the block: one for each status bit and one that is their OR.

Top module: `uart_regfile_top`

## Requirements
- R1: After reset the data, state, control, interrupt-status and baud-divisor registers read 0, all five interrupt outputs are low and tx_load is low.
- R2: pready is always 1 and pslverr is always 0. A read of any offset that is not one of the five registers (0x00, 0x04, 0x08, 0x0C, 0x10) and not an identification word returns 0.
- R3: A control write at 0x08 keeps only bits 6:0, and a baud-divisor write at 0x10 keeps only bits 19:0. Control bit 0 enables transmit (tx_en), bit 1 enables receive (rx_en), bit 2 is the TX interrupt enable, bit 3 is the RX interrupt enable, bit 4 is the TX-overrun interrupt enable, bit 5 is the RX-overrun interrupt enable and bit 6 drives hs_test.
- R4: When state bit 0 (tx-full) is clear, a write to 0x00 sets tx-full and raises tx_load for exactly the next cycle, with the written low byte on tx_byte. When tx-full is set, such a write instead sets state bit 2 (tx-overrun) and gives no tx_load.
- R5: A tx_done pulse while tx_en and tx-full are both set clears tx-full. It also sets interrupt-status bit 0 when control bit 2 is set.
- R6: An rx_valid pulse while rx_en is set stores rx_byte and sets state bit 1 (rx-full). If rx-full was already set, it also sets state bit 3 (rx-overrun). It sets interrupt-status bit 1 when control bit 3 is set. While rx_en is clear, rx_valid changes nothing.
- R7: A read of 0x00 returns the stored receive byte in bits 7:0 and clears rx-full.
- R8: State bits 0 and 1 ignore writes. Writing one to state bit 2 or 3 clears that bit.
- R9: Interrupt-status bits 2 and 3 always equal state bits 2 and 3 ANDed with control bits 4 and 5. Writing one to interrupt-status bit 2 or 3 clears state bit 2 or 3. Writing one to interrupt-status bit 0 or 1 clears that bit.
- R10: irq_tx, irq_rx, irq_txo and irq_rxo follow interrupt-status bits 0 to 3, and irq_any is high whenever any of those four bits is set.
- R11: The words at 0xFD0 to 0xFFC read 0x04, 0x00, 0x00, 0x00, 0x21, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in rising address order, and writes to them are ignored.
- R12: A transmit or receive interrupt event in the same cycle as a write-one-to-clear of its interrupt-status bit wins, so the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address in the window |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tx_done | input | 1 | Transmitter finished the loaded byte |
| rx_valid | input | 1 | Receiver presents a byte |
| rx_byte | input | 8 | Received byte |
| tx_load | output | 1 | One-cycle load pulse for the transmitter |
| tx_byte | output | 8 | Byte to transmit |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| hs_test | output | 1 | High-speed test mode bit |
| baud_div | output | BAUD_W | Baud divisor |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txo | output | 1 | Transmit overrun interrupt |
| irq_rxo | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of all interrupt bits |

## Verification
The transmit path is tried with one write into an empty buffer and then a second write into a full one. This separates the load pulse from the overrun path. The receive path gets two bytes with no read between them, then a byte while receive is disabled. The first case tells the overrun-plus-overwrite behaviour apart from capture, and the second tells a dropped byte apart from a stored one. The overrun enable is toggled while the overrun flag stays set, which shows whether the interrupt bit is a live AND or a latch. A clear and a new event are also placed in the same cycle to show which one wins.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam int RF_ADDR_W = 12;
  localparam int ID_WORDS  = 12;

  localparam logic [RF_ADDR_W-1:0] OFF_DATA  = 12'h000;
  localparam logic [RF_ADDR_W-1:0] OFF_STATE = 12'h004;
  localparam logic [RF_ADDR_W-1:0] OFF_CTRL  = 12'h008;
  localparam logic [RF_ADDR_W-1:0] OFF_ISTAT = 12'h00C;
  localparam logic [RF_ADDR_W-1:0] OFF_BAUD  = 12'h010;
  localparam logic [RF_ADDR_W-1:0] OFF_ID_LO = 12'hFD0;
  localparam logic [RF_ADDR_W-1:0] OFF_ID_HI = 12'hFFC;

  typedef enum logic [2:0] {
    RG_DATA, RG_STATE, RG_CTRL, RG_ISTAT, RG_BAUD, RG_ID, RG_NONE
  } region_e;

  // bit 0 is tx_en ... bit 6 is hs_test
  typedef struct packed {
    logic hs_test;
    logic rxo_ie;
    logic txo_ie;
    logic rx_ie;
    logic tx_ie;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    logic rx_ovr;
    logic tx_ovr;
    logic rx_full;
    logic tx_full;
  } state_t;

  typedef struct packed {
    logic data_wr;
    logic data_rd;
    logic state_wr;
    logic ctrl_wr;
    logic istat_wr;
    logic baud_wr;
  } strobe_t;

  // sticky bit update: a set in the same cycle beats a clear
  function automatic logic w1c_next(logic cur, logic clr, logic set);
    return (cur & ~clr) | set;
  endfunction

  // identification byte for word index 0..11 in rising address order
  function automatic logic [7:0] id_byte(logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h21;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
(
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [RF_ADDR_W-1:0] paddr,
  output region_e              region,
  output logic [3:0]           id_idx,
  output logic                 rd_active,
  output strobe_t              stb
);

  logic access;
  logic wr_act;

  assign access    = psel & penable;
  assign wr_act    = access & pwrite;
  assign rd_active = access & ~pwrite;

  always_comb begin
    region = RG_NONE;
    unique case (paddr)
      OFF_DATA:  region = RG_DATA;
      OFF_STATE: region = RG_STATE;
      OFF_CTRL:  region = RG_CTRL;
      OFF_ISTAT: region = RG_ISTAT;
      OFF_BAUD:  region = RG_BAUD;
      default: begin
        if (paddr >= OFF_ID_LO && paddr <= OFF_ID_HI && paddr[1:0] == 2'b00)
          region = RG_ID;
      end
    endcase
  end

  // 0xFD0 has [5:2] = 4, 0xFFC has [5:2] = 15
  assign id_idx = paddr[5:2] - 4'd4;

  always_comb begin
    stb          = '0;
    stb.data_wr  = wr_act    & (region == RG_DATA);
    stb.data_rd  = rd_active & (region == RG_DATA);
    stb.state_wr = wr_act    & (region == RG_STATE);
    stb.ctrl_wr  = wr_act    & (region == RG_CTRL);
    stb.istat_wr = wr_act    & (region == RG_ISTAT);
    stb.baud_wr  = wr_act    & (region == RG_BAUD);
  end

endmodule

// File: rtl/uart_rf_cfg.sv
module uart_rf_cfg
  import uart_rf_pkg::*;
#(
  parameter int BAUD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              baud_wr,
  input  logic [BAUD_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [BAUD_W-1:0] baud
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      baud <= '0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (baud_wr) baud <= wdata;
    end
  end

  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl == $past(wdata[CTRL_W-1:0])); // R3

  AST_BAUD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_wr |=> $stable(baud)); // R3

endmodule

// File: rtl/uart_rf_status.sv
module uart_rf_status
  import uart_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_t    stb,
  input  logic [7:0] wbyte,
  input  ctrl_t      ctrl,
  input  logic       tx_done,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output state_t     st,
  output logic [3:0] istat,
  output logic [7:0] rxbuf,
  output logic [7:0] txbuf,
  output logic       tx_load
);

  // named internal events
  logic tx_finish, rx_accept, load_take;
  logic clr_txo, clr_rxo, clr_txi, clr_rxi;
  logic txi, rxi;

  assign tx_finish = tx_done & ctrl.tx_en & st.tx_full;
  assign rx_accept = rx_valid & ctrl.rx_en;
  assign load_take = stb.data_wr & ~st.tx_full;

  assign clr_txo = (stb.state_wr | stb.istat_wr) & wbyte[2];
  assign clr_rxo = (stb.state_wr | stb.istat_wr) & wbyte[3];
  assign clr_txi = stb.istat_wr & wbyte[0];
  assign clr_rxi = stb.istat_wr & wbyte[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= '0;
      txi     <= 1'b0;
      rxi     <= 1'b0;
      rxbuf   <= '0;
      txbuf   <= '0;
      tx_load <= 1'b0;
    end else begin
      st.tx_full <= w1c_next(st.tx_full, tx_finish, load_take);
      st.rx_full <= w1c_next(st.rx_full, stb.data_rd, rx_accept);
      st.tx_ovr  <= w1c_next(st.tx_ovr, clr_txo, stb.data_wr & st.tx_full);
      st.rx_ovr  <= w1c_next(st.rx_ovr, clr_rxo, rx_accept & st.rx_full);
      txi        <= w1c_next(txi, clr_txi, tx_finish & ctrl.tx_ie);
      rxi        <= w1c_next(rxi, clr_rxi, rx_accept & ctrl.rx_ie);
      tx_load    <= load_take;
      if (stb.data_wr) txbuf <= wbyte;
      if (rx_accept)   rxbuf <= rx_byte;
    end
  end

  // overrun interrupt bits are live, not latched
  assign istat = {st.rx_ovr & ctrl.rxo_ie, st.tx_ovr & ctrl.txo_ie, rxi, txi};

  AST_TX_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load); // R4

  AST_TX_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stb.data_wr && !st.tx_full |=> st.tx_full && tx_load); // R4

  AST_TX_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stb.data_wr && st.tx_full |=> st.tx_ovr && !tx_load); // R4

  AST_TX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_finish |=> !st.tx_full); // R5

  AST_RX_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept && st.rx_full |=> st.rx_ovr); // R6

  AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !ctrl.rx_en && !stb.data_rd |=> $stable(rxbuf) && $stable(st.rx_full)); // R6

  AST_RX_FULL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    stb.data_rd && !rx_accept |=> !st.rx_full); // R7

  AST_RO_FULL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.state_wr && !load_take && !tx_finish |=> $stable(st.tx_full)); // R8

  AST_RX_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept && ctrl.rx_ie |=> istat[1]); // R12

  AST_TX_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_finish && ctrl.tx_ie |=> istat[0]); // R12

endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
  import uart_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BAUD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_active,
  input  region_e           region,
  input  logic [3:0]        id_idx,
  input  state_t            st,
  input  ctrl_t             ctrl,
  input  logic [3:0]        istat,
  input  logic [BAUD_W-1:0] baud,
  input  logic [7:0]        rxbuf,
  output logic [DATA_W-1:0] prdata
);

  always_comb begin
    prdata = '0;
    if (rd_active) begin
      unique case (region)
        RG_DATA:  prdata = DATA_W'(rxbuf);
        RG_STATE: prdata = DATA_W'(st);
        RG_CTRL:  prdata = DATA_W'(ctrl);
        RG_ISTAT: prdata = DATA_W'(istat);
        RG_BAUD:  prdata = DATA_W'(baud);
        RG_ID:    prdata = DATA_W'(id_byte(id_idx));
        default:  prdata = '0;
      endcase
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active && region == RG_NONE |-> prdata == '0); // R2

endmodule

// File: rtl/uart_regfile_top.sv
module uart_regfile_top
  import uart_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BAUD_W = 20
) (
  input  logic                 pclk,
  input  logic                 presetn,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [RF_ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0]    pwdata,
  output logic [DATA_W-1:0]    prdata,
  output logic                 pready,
  output logic                 pslverr,
  input  logic                 tx_done,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  output logic                 tx_load,
  output logic [7:0]           tx_byte,
  output logic                 tx_en,
  output logic                 rx_en,
  output logic                 hs_test,
  output logic [BAUD_W-1:0]    baud_div,
  output logic                 irq_tx,
  output logic                 irq_rx,
  output logic                 irq_txo,
  output logic                 irq_rxo,
  output logic                 irq_any
);

  region_e    region;
  logic [3:0] id_idx;
  logic       rd_active;
  strobe_t    stb;
  ctrl_t      ctrl;
  state_t     st;
  logic [3:0] istat;
  logic [7:0] rxbuf;
  logic       pwdata_unused;

  assign pwdata_unused = ^pwdata[DATA_W-1:BAUD_W];

  uart_rf_decode u_decode (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .region    (region),
    .id_idx    (id_idx),
    .rd_active (rd_active),
    .stb       (stb)
  );

  uart_rf_cfg #(.BAUD_W(BAUD_W)) u_cfg (
    .clk     (pclk),
    .rst_n   (presetn),
    .ctrl_wr (stb.ctrl_wr),
    .baud_wr (stb.baud_wr),
    .wdata   (pwdata[BAUD_W-1:0]),
    .ctrl    (ctrl),
    .baud    (baud_div)
  );

  uart_rf_status u_status (
    .clk      (pclk),
    .rst_n    (presetn),
    .stb      (stb),
    .wbyte    (pwdata[7:0]),
    .ctrl     (ctrl),
    .tx_done  (tx_done),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .st       (st),
    .istat    (istat),
    .rxbuf    (rxbuf),
    .txbuf    (tx_byte),
    .tx_load  (tx_load)
  );

  uart_rf_rdmux #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) u_rdmux (
    .clk       (pclk),
    .rst_n     (presetn),
    .rd_active (rd_active),
    .region    (region),
    .id_idx    (id_idx),
    .st        (st),
    .ctrl      (ctrl),
    .istat     (istat),
    .baud      (baud_div),
    .rxbuf     (rxbuf),
    .prdata    (prdata)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign tx_en   = ctrl.tx_en;
  assign rx_en   = ctrl.rx_en;
  assign hs_test = ctrl.hs_test;
  assign irq_tx  = istat[0];
  assign irq_rx  = istat[1];
  assign irq_txo = istat[2];
  assign irq_rxo = istat[3];
  assign irq_any = |istat;

  AST_ANY_COVERS_TXO: assert property (@(posedge pclk) disable iff (!presetn)
    st.tx_ovr && ctrl.txo_ie |-> irq_any && irq_txo); // R10

  AST_ANY_COVERS_RXO: assert property (@(posedge pclk) disable iff (!presetn)
    st.rx_ovr && ctrl.rxo_ie |-> irq_any && irq_rxo); // R9

endmodule

// File: tb/uart_regfile_top_tb_top.sv
module uart_regfile_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int BAUD_W = 20;

  logic              pclk = 1'b0;
  logic              presetn = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0]       paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic [DATA_W-1:0] prdata;
  logic              pready, pslverr;
  logic              tx_done = 1'b0, rx_valid = 1'b0;
  logic [7:0]        rx_byte = '0;
  logic              tx_load, tx_en, rx_en, hs_test;
  logic [7:0]        tx_byte;
  logic [BAUD_W-1:0] baud_div;
  logic              irq_tx, irq_rx, irq_txo, irq_rxo, irq_any;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) pclk = ~pclk;

  uart_regfile_top #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_load(tx_load),
    .tx_byte(tx_byte), .tx_en(tx_en), .rx_en(rx_en), .hs_test(hs_test),
    .baud_div(baud_div), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_txo(irq_txo), .irq_rxo(irq_rxo), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // irq pins as {any, rxo, txo, rx, tx}
  task automatic chk_irq(input string tag, input logic [4:0] exp);
    chk(tag, {27'd0, irq_any, irq_rxo, irq_txo, irq_rx, irq_tx}, {27'd0, exp});
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  // driver: push expected value, then run the read
  task automatic apb_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse_rx(input logic [7:0] b);
    @(negedge pclk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge pclk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_txdone();
    @(negedge pclk);
    tx_done = 1'b1;
    @(negedge pclk);
    tx_done = 1'b0;
  endtask

  // monitor: samples a quarter period after the falling edge
  always begin
    @(negedge pclk);
    #(CLK_PERIOD/4);
    if (psel && penable) begin
      chk("R2 pready", {31'd0, pready}, 32'd1);
      chk("R2 pslverr", {31'd0, pslverr}, 32'd0);
      if (!pwrite) begin
        if (exp_q.size() == 0) begin
          chk("scoreboard underflow", 32'd1, 32'd0);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(t, prdata, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ids [12];
    ids = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h21, 8'hB8, 8'h1B, 8'h00,
            8'h0D, 8'hF0, 8'h05, 8'hB1};

    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R1 reset state
    apb_rd(12'h000, 32'h0, "R1 data");
    apb_rd(12'h004, 32'h0, "R1 state");
    apb_rd(12'h008, 32'h0, "R1 ctrl");
    apb_rd(12'h00C, 32'h0, "R1 istat");
    apb_rd(12'h010, 32'h0, "R1 baud");
    chk_irq("R1 irqs", 5'b00000);
    chk("R1 tx_load", {31'd0, tx_load}, 32'd0);

    // R2 unmapped
    apb_rd(12'h014, 32'h0, "R2 unmapped 0x014");
    apb_rd(12'hFCC, 32'h0, "R2 unmapped 0xFCC");
    apb_rd(12'hFD2, 32'h0, "R2 misaligned id");

    // R3 masking
    apb_wr(12'h008, 32'hFFFF_FFFF);
    apb_rd(12'h008, 32'h7F, "R3 ctrl mask");
    chk("R3 hs_test", {31'd0, hs_test}, 32'd1);
    apb_wr(12'h010, 32'hFFFF_FFFF);
    apb_rd(12'h010, 32'h000F_FFFF, "R3 baud mask");
    chk("R3 baud_div", {12'd0, baud_div}, 32'h000F_FFFF);
    apb_wr(12'h008, 32'h3F);
    chk("R3 enables", {30'd0, tx_en, rx_en}, 32'd3);

    // R11 identification words
    for (int i = 0; i < 12; i++)
      apb_rd(12'hFD0 + 12'(i * 4), {24'd0, ids[i]}, "R11 id word");
    apb_wr(12'hFE0, 32'hFFFF_FFFF);
    apb_rd(12'hFE0, 32'h21, "R11 id write ignored");

    // R4 load then overrun
    apb_wr(12'h000, 32'h0000_125A);
    chk("R4 tx_load pulse", {31'd0, tx_load}, 32'd1);
    chk("R4 tx_byte", {24'd0, tx_byte}, 32'h5A);
    @(negedge pclk);
    chk("R4 tx_load single", {31'd0, tx_load}, 32'd0);
    apb_rd(12'h004, 32'h1, "R4 tx-full");
    apb_wr(12'h000, 32'h33);
    chk("R4 no load when full", {31'd0, tx_load}, 32'd0);
    apb_rd(12'h004, 32'h5, "R4 tx-overrun");
    apb_rd(12'h00C, 32'h4, "R9 txo istat");
    chk_irq("R10 txo irq", 5'b10100);

    // R5 transmit done
    pulse_txdone();
    apb_rd(12'h004, 32'h4, "R5 tx-full cleared");
    apb_rd(12'h00C, 32'h5, "R5 tx istat");
    chk_irq("R10 tx+txo irq", 5'b10101);

    // R9 clear via istat clears state overrun
    apb_wr(12'h00C, 32'h4);
    apb_rd(12'h004, 32'h0, "R9 state ovr cleared");
    apb_rd(12'h00C, 32'h1, "R9 istat after clear");

    // R9 live AND with enable
    apb_wr(12'h000, 32'h11);
    apb_wr(12'h000, 32'h22);
    apb_rd(12'h004, 32'h5, "R4 second overrun");
    apb_wr(12'h008, 32'h2F);
    apb_rd(12'h00C, 32'h1, "R9 txo masked");
    chk_irq("R10 txo masked", 5'b10001);
    apb_wr(12'h008, 32'h3F);
    apb_rd(12'h00C, 32'h5, "R9 txo unmasked");

    // R8 state write: full bits read-only, overruns W1C
    apb_wr(12'h004, 32'hF);
    apb_rd(12'h004, 32'h1, "R8 state W1C");
    apb_wr(12'h00C, 32'h1);
    apb_rd(12'h00C, 32'h0, "R9 tx istat cleared");
    chk_irq("R10 all low", 5'b00000);
    pulse_txdone();
    apb_rd(12'h004, 32'h0, "R5 drained");
    apb_wr(12'h00C, 32'h1);

    // R6 receive and overrun
    pulse_rx(8'hA5);
    apb_rd(12'h004, 32'h2, "R6 rx-full");
    apb_rd(12'h00C, 32'h2, "R6 rx istat");
    chk_irq("R10 rx irq", 5'b10010);
    pulse_rx(8'h3C);
    apb_rd(12'h004, 32'hA, "R6 rx-overrun");
    apb_rd(12'h00C, 32'hA, "R9 rxo istat");
    chk_irq("R10 rx+rxo irq", 5'b11010);

    // R7 data read
    apb_rd(12'h000, 32'h3C, "R7 data read");
    apb_rd(12'h004, 32'h8, "R7 rx-full cleared");
    apb_wr(12'h00C, 32'hA);
    apb_rd(12'h004, 32'h0, "R9 rx ovr cleared");
    apb_rd(12'h00C, 32'h0, "R9 istat zero");

    // R6 receive disabled: byte dropped
    apb_wr(12'h008, 32'h3D);
    pulse_rx(8'h77);
    apb_rd(12'h004, 32'h0, "R6 dropped state");
    apb_rd(12'h00C, 32'h0, "R6 dropped istat");
    apb_rd(12'h000, 32'h3C, "R6 buffer unchanged");
    apb_wr(12'h008, 32'h3F);

    // R12 event beats clear
    pulse_rx(8'h81);
    apb_rd(12'h000, 32'h81, "R7 read again");
    fork
      apb_wr(12'h00C, 32'h2);
      begin
        @(negedge pclk);
        @(negedge pclk);
        rx_valid = 1'b1; rx_byte = 8'h99;
        @(negedge pclk);
        rx_valid = 1'b0;
      end
    join
    apb_rd(12'h00C, 32'h2, "R12 rx istat kept");
    apb_rd(12'h004, 32'h2, "R12 state");
    apb_rd(12'h000, 32'h99, "R12 new byte");

    @(negedge pclk);
    @(negedge pclk);
    chk("scoreboard drained", exp_q.size(), 32'd0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule